// File: doc/BRIEF.md
# Staggered Two-Slice 64-bit Integer ALU

This block is a pipelined 64-bit integer ALU for additive and bitwise operations. The datapath is two 32-bit slices that run one pipeline stage apart. The lower slice works on bits 31:0 first. Its carry-out is held in a register for one stage and then feeds the upper slice, which works on bits 63:32. The upper operand halves and the opcode are delayed by one register so that they reach the upper slice in the same cycle as that carry.

A new operation can enter on every clock cycle, and the stagger never holds back issue. The low 32 bits of each result appear one stage before the full 64-bit result, with their own valid. A consumer such as an address path can therefore start on the low half early.

A 32-bit mode input changes this timing. In that mode the full-result valid fires in the same cycle as the low-half valid, and the upper half of the full result is zero.

Top module: `stag_alu64`

## Requirements
- R1: A synchronous active-high `rst` clears `lo_valid` and `full_valid` after the clock edge that samples it, and also drops every operation in flight.
- R2: Opcode 3'b000 adds the operands. `full_res` is (a+b) mod 2^64 and `full_cout` is the carry out of bit 63.
- R3: Opcode 3'b001 subtracts as a + ~b + 1. `full_cout` is 1 exactly when there is no borrow, that is when a >= b unsigned.
- R4: Opcodes 3'b010 (AND), 3'b011 (OR) and 3'b100 (XOR) give the bitwise result with `full_cout` = 0. No carry passes between the slices for these opcodes.
- R5: Opcodes 3'b101, 3'b110 and 3'b111 give a zero result and `full_cout` = 0.
- R6: A carry or borrow out of bit 31 of the lower slice reaches bit 32 of the upper slice. For example, 0x00000000_FFFFFFFF + 1 gives 0x00000001_00000000.
- R7: If `in_valid` is high at rising edge E, then `lo_valid` and `lo_res` (result bits 31:0) are presented after edge E+1. In 64-bit mode, `full_valid`, `full_res` and `full_cout` are presented after edge E+2.
- R8: Operations issued on consecutive cycles produce results on consecutive cycles, in issue order, with no stall.
- R9: With `in_narrow` high, `full_valid` fires in the same cycle as `lo_valid`. `full_res[63:32]` is zero and `full_cout` is the carry out of bit 31 (0 for logic and unused opcodes).
- R10: A cycle with `in_valid` low produces no `lo_valid` and no `full_valid` for that slot.
- R11: `in_narrow` may change only when `in_valid` was low on the two previous edges. The bench always leaves the pipeline empty before it changes mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation issue strobe |
| in_op | input | 3 | Opcode |
| in_a | input | 64 | First operand |
| in_b | input | 64 | Second operand |
| in_narrow | input | 1 | 32-bit mode |
| lo_valid | output | 1 | Low half of the result is valid |
| lo_res | output | 32 | Result bits 31:0 |
| full_valid | output | 1 | Full result is valid |
| full_res | output | 64 | Full result |
| full_cout | output | 1 | Final carry-out |

## Verification
The bench builds the block with its default slice width of 32, so the split falls at bit 32. This makes the stagger directly visible: operands chosen to carry across that boundary show whether the registered carry lands on the right operation in the following stage. Long back-to-back runs and runs with random bubbles, in both modes, check that the two output timings stay aligned with the reference queue. A reset applied while operations are in flight checks that no stale valid escapes.

// File: rtl/stag_alu64.sv
module stag_alu64 #(
  parameter int SLICE_W = 32,
  parameter int OP_W    = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [OP_W-1:0]      in_op,
  input  logic [2*SLICE_W-1:0] in_a,
  input  logic [2*SLICE_W-1:0] in_b,
  input  logic                 in_narrow,
  output logic                 lo_valid,
  output logic [SLICE_W-1:0]   lo_res,
  output logic                 full_valid,
  output logic [2*SLICE_W-1:0] full_res,
  output logic                 full_cout
);
  localparam int DW = 2 * SLICE_W;
  localparam logic [OP_W-1:0] OP_ADD = OP_W'(0);
  localparam logic [OP_W-1:0] OP_SUB = OP_W'(1);
  localparam logic [OP_W-1:0] OP_AND = OP_W'(2);
  localparam logic [OP_W-1:0] OP_OR  = OP_W'(3);
  localparam logic [OP_W-1:0] OP_XOR = OP_W'(4);

  function automatic logic [SLICE_W:0] slice_op(input logic [OP_W-1:0] op,
                                               input logic [SLICE_W-1:0] a,
                                               input logic [SLICE_W-1:0] b,
                                               input logic cin);
    logic [SLICE_W:0] r;
    case (op)
      OP_ADD:  r = {1'b0, a} + {1'b0, b} + {{SLICE_W{1'b0}}, cin};
      OP_SUB:  r = {1'b0, a} + {1'b0, ~b} + {{SLICE_W{1'b0}}, cin};
      OP_AND:  r = {1'b0, a & b};
      OP_OR:   r = {1'b0, a | b};
      OP_XOR:  r = {1'b0, a ^ b};
      default: r = '0;
    endcase
    return r;
  endfunction

  // issue register
  logic                s1_v, s1_n;
  logic [OP_W-1:0]     s1_op;
  logic [DW-1:0]       s1_a, s1_b;

  always_ff @(posedge clk) begin
    if (rst) s1_v <= 1'b0;
    else     s1_v <= in_valid;
    s1_op <= in_op;
    s1_a  <= in_a;
    s1_b  <= in_b;
    s1_n  <= in_narrow;
  end

  // lower slice
  logic [SLICE_W:0] lo_sum;
  assign lo_sum = slice_op(s1_op, s1_a[SLICE_W-1:0], s1_b[SLICE_W-1:0], s1_op == OP_SUB);

  logic                s2_v, s2_n, s2_c;
  logic [OP_W-1:0]     s2_op;
  logic [SLICE_W-1:0]  s2_ahi, s2_bhi, s2_lo;

  always_ff @(posedge clk) begin
    if (rst) s2_v <= 1'b0;
    else     s2_v <= s1_v;
    s2_n   <= s1_n;
    s2_op  <= s1_op;
    s2_ahi <= s1_a[DW-1:SLICE_W];
    s2_bhi <= s1_b[DW-1:SLICE_W];
    s2_lo  <= lo_sum[SLICE_W-1:0];
    s2_c   <= lo_sum[SLICE_W];
  end

  // upper slice, fed by the registered carry
  logic [SLICE_W:0] hi_sum;
  assign hi_sum = slice_op(s2_op, s2_ahi, s2_bhi, s2_c);

  logic          s3_v, s3_c;
  logic [DW-1:0] s3_res;

  always_ff @(posedge clk) begin
    if (rst) s3_v <= 1'b0;
    else     s3_v <= s2_v & ~s2_n;
    s3_res <= {hi_sum[SLICE_W-1:0], s2_lo};
    s3_c   <= hi_sum[SLICE_W];
  end

  logic narrow_out;
  assign narrow_out = s2_v & s2_n;

  assign lo_valid   = s2_v;
  assign lo_res     = s2_lo;
  assign full_valid = s3_v | narrow_out;
  assign full_res   = narrow_out ? {{SLICE_W{1'b0}}, s2_lo} : s3_res;
  assign full_cout  = narrow_out ? s2_c : s3_c;
endmodule

module stag_alu64_chk #(
  parameter int SLICE_W = 32,
  parameter int OP_W    = 3
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic [OP_W-1:0]      in_op,
  input logic                 in_narrow,
  input logic                 lo_valid,
  input logic                 full_valid,
  input logic [2*SLICE_W-1:0] full_res,
  input logic                 full_cout
);
  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !lo_valid && !full_valid);

  p_lo_latency_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> ##1 lo_valid);

  p_full_latency_r7: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_narrow |=> ##2 full_valid);

  p_logic_no_carry_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_narrow && (in_op == OP_W'(2) || in_op == OP_W'(3) || in_op == OP_W'(4))
    |=> ##2 !full_cout);

  p_unused_zero_r5: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_narrow && in_op > OP_W'(4) |=> ##2 (full_res == '0 && !full_cout));

  p_narrow_align_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_narrow |=> ##1 (full_valid && lo_valid && full_res[2*SLICE_W-1:SLICE_W] == '0));

  p_bubble_r10: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ##1 !lo_valid);

  p_mode_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(in_narrow) |-> !$past(in_valid) && !$past(in_valid, 2));
endmodule

bind stag_alu64 stag_alu64_chk #(.SLICE_W(SLICE_W), .OP_W(OP_W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_narrow(in_narrow),
  .lo_valid(lo_valid), .full_valid(full_valid), .full_res(full_res), .full_cout(full_cout)
);

// File: tb/stag_alu64_tb_top.sv
module stag_alu64_tb_top;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_op = '0;
  logic [63:0] in_a = '0, in_b = '0;
  logic        in_narrow = 1'b0;
  logic        lo_valid, full_valid, full_cout;
  logic [31:0] lo_res;
  logic [63:0] full_res;

  stag_alu64 dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_a(in_a), .in_b(in_b),
    .in_narrow(in_narrow), .lo_valid(lo_valid), .lo_res(lo_res), .full_valid(full_valid),
    .full_res(full_res), .full_cout(full_cout)
  );

  typedef struct {
    logic        v;
    logic [2:0]  op;
    logic [63:0] a, b;
    logic        n;
    string       tag;
  } ent_t;

  ent_t hist[$];
  int   n_run = 0, n_fail = 0;
  bit   done = 0;
  bit   after_rst = 0;

  function automatic logic [64:0] model(ent_t e);
    logic [64:0] r;
    logic [32:0] s;
    if (e.n) begin
      case (e.op)
        3'd0: s = {1'b0, e.a[31:0]} + {1'b0, e.b[31:0]};
        3'd1: s = {1'b0, e.a[31:0]} + {1'b0, ~e.b[31:0]} + 33'd1;
        3'd2: s = {1'b0, e.a[31:0] & e.b[31:0]};
        3'd3: s = {1'b0, e.a[31:0] | e.b[31:0]};
        3'd4: s = {1'b0, e.a[31:0] ^ e.b[31:0]};
        default: s = '0;
      endcase
      r = {s[32], 32'd0, s[31:0]};
    end else begin
      case (e.op)
        3'd0: r = {1'b0, e.a} + {1'b0, e.b};
        3'd1: r = {1'b0, e.a} + {1'b0, ~e.b} + 65'd1;
        3'd2: r = {1'b0, e.a & e.b};
        3'd3: r = {1'b0, e.a | e.b};
        3'd4: r = {1'b0, e.a ^ e.b};
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  function automatic string tag_of(logic [2:0] op, logic n);
    if (n) return "R9";
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2, 3'd3, 3'd4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [64:0] act, logic [64:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare();
    bit e_lo, nar, wid, e_fv;
    logic [64:0] ex;
    ent_t src;
    e_lo = hist[1].v;
    chk(lo_valid === e_lo, after_rst ? "R1" : (e_lo ? "R7" : "R10"), {64'd0, lo_valid}, {64'd0, e_lo});
    if (e_lo) begin
      ex = model(hist[1]);
      chk(lo_res === ex[31:0], "R7", {33'd0, lo_res}, {33'd0, ex[31:0]});
    end
    nar  = hist[1].v && hist[1].n;
    wid  = hist[2].v && !hist[2].n;
    e_fv = nar || wid;
    chk(full_valid === e_fv, after_rst ? "R1" : (nar ? "R9" : (wid ? "R7" : "R10")),
        {64'd0, full_valid}, {64'd0, e_fv});
    if (e_fv) begin
      src = nar ? hist[1] : hist[2];
      ex = model(src);
      chk({full_cout, full_res} === ex, src.tag, {full_cout, full_res}, ex);
    end
  endtask

  task automatic cyc(bit v, logic [2:0] op, logic [63:0] a, logic [63:0] b, string tag = "");
    ent_t e;
    in_valid = v; in_op = op; in_a = a; in_b = b;
    @(posedge clk);
    e.v = v; e.op = op; e.a = a; e.b = b; e.n = in_narrow;
    e.tag = (tag == "") ? tag_of(op, in_narrow) : tag;
    hist.push_front(e);
    if (hist.size() > 4) void'(hist.pop_back());
    after_rst = rst;
    if (rst) foreach (hist[i]) hist[i].v = 1'b0;
    @(negedge clk);
    compare();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 64'd0, 64'd0);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    ent_t z;
    z.v = 0; z.op = 0; z.a = 0; z.b = 0; z.n = 0; z.tag = "";
    for (int i = 0; i < 4; i++) hist.push_back(z);
    @(negedge clk);
    idle(3);                       // R1: valids low under reset
    rst = 1'b0;
    idle(2);

    cyc(1, 3'd0, 64'd5, 64'd7);
    cyc(1, 3'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, "R6");
    cyc(1, 3'd1, 64'h0000_0001_0000_0000, 64'd1, "R6");
    cyc(1, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, "R6");
    cyc(1, 3'd1, 64'd3, 64'd9);
    cyc(1, 3'd1, 64'd9, 64'd9);
    cyc(1, 3'd2, 64'hF0F0_FFFF_FFFF_0000, 64'h0FF0_FFFF_FFFF_FFFF);
    cyc(1, 3'd3, 64'h1234_0000_8000_0000, 64'h0000_5678_8000_0000);
    cyc(1, 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0001_FFFF_FFFF);
    for (int op = 5; op < 8; op++) cyc(1, op[2:0], r64(), r64());
    idle(4);

    for (int i = 0; i < 300; i++) cyc(1, 3'($urandom_range(0, 7)), r64(), r64(), "R8");
    for (int i = 0; i < 300; i++)
      cyc(1'($urandom_range(0, 1)), 3'($urandom_range(0, 7)), r64(), r64());
    idle(3);

    // R11: pipeline drained before mode change
    chk(!lo_valid && !full_valid, "R11", {63'd0, lo_valid, full_valid}, 65'd0);
    in_narrow = 1'b1;
    cyc(1, 3'd0, 64'h5555_5555_FFFF_FFFF, 64'h1, "R9");
    cyc(1, 3'd1, 64'd2, 64'd5, "R9");
    for (int i = 0; i < 300; i++)
      cyc(1'($urandom_range(0, 3) != 0), 3'($urandom_range(0, 7)), r64(), r64());
    idle(3);
    chk(!lo_valid && !full_valid, "R11", {63'd0, lo_valid, full_valid}, 65'd0);
    in_narrow = 1'b0;

    for (int i = 0; i < 6; i++) cyc(1, 3'($urandom_range(0, 4)), r64(), r64());
    rst = 1'b1;                    // R1: reset with work in flight
    cyc(1, 3'd0, r64(), r64());
    rst = 1'b0;
    idle(4);
    for (int i = 0; i < 50; i++) cyc(1, 3'($urandom_range(0, 7)), r64(), r64());
    idle(4);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule